// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block is a watchdog whose counter runs on a dedicated watchdog clock, unrelated to the system clock. Because of that, it keeps counting while the system clock is halted during a low-power sleep state. Software keeps the watchdog quiet by pulsing a kick input from the system domain. The kick crosses into the watchdog domain and restarts the count.

When the count expires, the action depends on the power state seen in the watchdog domain:
- If the device is running, the block requests a system reset. This is a pulse of fixed length in the system domain.
- If the device is asleep, the block raises a wake-up request instead. The request is first available as a level in the watchdog domain, so clock control can use it while the system clock is still stopped. It is then repeated in the system domain, where it stays high until the system acknowledges it.

The transition into sleep also restarts the count.

The counter is free running. Without kicks it expires once every `TIMEOUT` watchdog cycles, indefinitely.

Top module: `sleepwdt`

## Requirements
- R1: While and after reset (`wrst` and `srst` high together), `wdt_rst_o`, `wake_req_o` and `wake_wclk_o` are low.
- R2: The counter advances once per `wclk` cycle from 0 up to `TIMEOUT-1` and then returns to 0. With no kick, an expiry therefore occurs every `TIMEOUT` watchdog cycles, and successive reset pulses start `TIMEOUT` watchdog cycles apart.
- R3: A one-cycle high on `kick_i` (sampled on `sclk`) sets the counter to 0. The next expiry falls `TIMEOUT` watchdog cycles after that clear. Kicks spaced closer than `TIMEOUT` watchdog cycles prevent any expiry.
- R4: An expiry while the synchronized `sleep_i` is low produces a reset pulse on `wdt_rst_o`.
- R5: Every reset pulse is high for exactly `RST_LEN` consecutive `sclk` cycles.
- R6: An expiry while the synchronized `sleep_i` is high produces no reset pulse. Instead it sets `wake_wclk_o` (watchdog domain) and then `wake_req_o` (system domain).
- R7: `wake_req_o` stays high until `wake_ack_i` is sampled high, and falls on the following `sclk` edge. `wake_wclk_o` clears once that acknowledge has crossed into the watchdog domain.
- R8: A rising edge of `sleep_i` sets the counter to 0. The wake-up then arrives `TIMEOUT` watchdog cycles after sleep entry, not after the last kick.
- R9: `wake_wclk_o` rises on time even when `sclk` is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Watchdog clock, independent of the system clock |
| wrst | input | 1 | Synchronous active-high reset, watchdog domain |
| sclk | input | 1 | System clock, may be stopped during sleep |
| srst | input | 1 | Synchronous active-high reset, system domain |
| kick_i | input | 1 | One-cycle clear request, system domain |
| sleep_i | input | 1 | High while the system is asleep |
| wake_ack_i | input | 1 | Acknowledge of the wake-up request, system domain |
| wdt_rst_o | output | 1 | Reset pulse, `RST_LEN` system cycles long |
| wake_req_o | output | 1 | Wake-up request level, system domain |
| wake_wclk_o | output | 1 | Wake-up request level, watchdog domain |

## Verification
A kick or sleep entry reaches the counter after one system register and about three watchdog edges. The resulting expiry appears on `wdt_rst_o` or `wake_req_o` roughly `TIMEOUT` watchdog cycles later, plus a two-stage synchronizer and one output register in the system domain. Because the two clocks are unrelated, each expected event is queued with an earliest and latest time derived from these counts, and the monitor checks the observed rising edge against that window.

Two results are checked on exact cycle counts instead:
- the pulse length, counted in system cycles on each falling edge;
- the drop of `wake_req_o`, sampled two system edges after the acknowledge.

// File: rtl/sleepwdt_pkg.sv
package sleepwdt_pkg;

  // Kind of expiry decided in the watchdog domain.
  typedef enum logic [1:0] {
    EXP_NONE  = 2'd0,
    EXP_RESET = 2'd1,
    EXP_WAKE  = 2'd2
  } wdt_exp_e;

endpackage

// File: rtl/sleepwdt_sync.sv
module sleepwdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sleepwdt_kick_xfer.sv
module sleepwdt_kick_xfer #(
  parameter int STAGES = 2
) (
  input  logic sclk,
  input  logic srst,
  input  logic kick,
  input  logic wclk,
  input  logic wrst,
  output logic kick_w
);

  logic tog_s;
  logic tog_w;
  logic tog_w_d;

  // System side: every kick flips a level.
  always_ff @(posedge sclk) begin
    if (srst) tog_s <= 1'b0;
    else      tog_s <= tog_s ^ kick;
  end

  sleepwdt_sync #(.STAGES(STAGES)) u_sync (
    .clk (wclk),
    .rst (wrst),
    .d   (tog_s),
    .q   (tog_w)
  );

  // Watchdog side: each level change becomes a one-cycle pulse.
  always_ff @(posedge wclk) begin
    if (wrst) tog_w_d <= 1'b0;
    else      tog_w_d <= tog_w;
  end

  assign kick_w = tog_w ^ tog_w_d;

endmodule

// File: rtl/sleepwdt_core.sv
module sleepwdt_core
  import sleepwdt_pkg::*;
#(
  parameter int TIMEOUT = 65536,
  parameter int STAGES  = 2,
  localparam int CW     = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kick_w,
  input  logic          sleep_a,
  input  logic          ack_a,
  output logic          rst_tog_o,
  output logic          wake_o,
  output logic [CW-1:0] cnt_o,
  output logic          clr_o,
  output logic          sleep_o
);

  localparam logic [CW-1:0] TOP = CW'(TIMEOUT - 1);

  logic          sleep_s;
  logic          sleep_d;
  logic          ack_s;
  logic          sleep_rise;
  logic          clr;
  logic          at_top;
  logic [CW-1:0] cnt_q;
  logic          rst_tog_q;
  logic          wake_q;
  wdt_exp_e      exp_kind;

  sleepwdt_sync #(.STAGES(STAGES)) u_sleep_sync (
    .clk (clk),
    .rst (rst),
    .d   (sleep_a),
    .q   (sleep_s)
  );

  sleepwdt_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_a),
    .q   (ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sleep_d <= 1'b0;
    else     sleep_d <= sleep_s;
  end

  assign sleep_rise = sleep_s & ~sleep_d;
  assign clr        = kick_w | sleep_rise;
  assign at_top     = (cnt_q == TOP);

  // A clear in the same cycle as the last count wins over the expiry.
  always_comb begin
    exp_kind = EXP_NONE;
    if (at_top && !clr) begin
      exp_kind = sleep_s ? EXP_WAKE : EXP_RESET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (clr || at_top) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                        rst_tog_q <= 1'b0;
    else if (exp_kind == EXP_RESET) rst_tog_q <= ~rst_tog_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                       wake_q <= 1'b0;
    else if (exp_kind == EXP_WAKE) wake_q <= 1'b1;
    else if (ack_s)                wake_q <= 1'b0;
  end

  assign rst_tog_o = rst_tog_q;
  assign wake_o    = wake_q;
  assign cnt_o     = cnt_q;
  assign clr_o     = clr;
  assign sleep_o   = sleep_s;

endmodule

// File: rtl/sleepwdt_sys_side.sv
module sleepwdt_sys_side #(
  parameter int RST_LEN = 8,
  parameter int STAGES  = 2,
  localparam int LW     = $clog2(RST_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_tog_a,
  input  logic wake_a,
  input  logic wake_ack,
  output logic rst_pulse_o,
  output logic wake_req_o,
  output logic ack_lvl_o
);

  logic          tog_s;
  logic          tog_d;
  logic          fire;
  logic [LW-1:0] left_q;
  logic          pulse_q;
  logic          flag_s;
  logic          ack_q;
  logic          ack_n;
  logic          req_q;

  sleepwdt_sync #(.STAGES(STAGES)) u_tog_sync (
    .clk (clk),
    .rst (rst),
    .d   (rst_tog_a),
    .q   (tog_s)
  );

  sleepwdt_sync #(.STAGES(STAGES)) u_wake_sync (
    .clk (clk),
    .rst (rst),
    .d   (wake_a),
    .q   (flag_s)
  );

  always_ff @(posedge clk) begin
    if (rst) tog_d <= 1'b0;
    else     tog_d <= tog_s;
  end

  assign fire = tog_s ^ tog_d;

  // Pulse stretcher: high for RST_LEN edges after each event.
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else if (fire) begin
      pulse_q <= 1'b1;
      left_q  <= LW'(RST_LEN - 1);
    end else if (left_q != '0) begin
      left_q  <= left_q - LW'(1);
    end else begin
      pulse_q <= 1'b0;
    end
  end

  // Four-phase handshake: acknowledge level is held until the flag drops.
  assign ack_n = flag_s ? (ack_q | (wake_ack & req_q)) : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      ack_q <= ack_n;
      req_q <= flag_s & ~ack_n;
    end
  end

  assign rst_pulse_o = pulse_q;
  assign wake_req_o  = req_q;
  assign ack_lvl_o   = ack_q;

endmodule

// File: rtl/sleepwdt.sv
module sleepwdt #(
  parameter int TIMEOUT = 65536,
  parameter int RST_LEN = 8,
  parameter int STAGES  = 2,
  localparam int CW     = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic wclk,
  input  logic wrst,
  input  logic sclk,
  input  logic srst,
  input  logic kick_i,
  input  logic sleep_i,
  input  logic wake_ack_i,
  output logic wdt_rst_o,
  output logic wake_req_o,
  output logic wake_wclk_o
);

  logic          kick_w;
  logic          rst_tog;
  logic          wake_flag;
  logic          ack_lvl;
  logic [CW-1:0] wd_cnt;
  logic          wd_clr;
  logic          wd_sleep;

  sleepwdt_kick_xfer #(.STAGES(STAGES)) u_kick (
    .sclk   (sclk),
    .srst   (srst),
    .kick   (kick_i),
    .wclk   (wclk),
    .wrst   (wrst),
    .kick_w (kick_w)
  );

  sleepwdt_core #(.TIMEOUT(TIMEOUT), .STAGES(STAGES)) u_core (
    .clk       (wclk),
    .rst       (wrst),
    .kick_w    (kick_w),
    .sleep_a   (sleep_i),
    .ack_a     (ack_lvl),
    .rst_tog_o (rst_tog),
    .wake_o    (wake_flag),
    .cnt_o     (wd_cnt),
    .clr_o     (wd_clr),
    .sleep_o   (wd_sleep)
  );

  sleepwdt_sys_side #(.RST_LEN(RST_LEN), .STAGES(STAGES)) u_sys (
    .clk         (sclk),
    .rst         (srst),
    .rst_tog_a   (rst_tog),
    .wake_a      (wake_flag),
    .wake_ack    (wake_ack_i),
    .rst_pulse_o (wdt_rst_o),
    .wake_req_o  (wake_req_o),
    .ack_lvl_o   (ack_lvl)
  );

  assign wake_wclk_o = wake_flag;

endmodule

// File: rtl/sleepwdt_chk.sv
module sleepwdt_chk #(
  parameter int TIMEOUT = 65536,
  parameter int RST_LEN = 8,
  localparam int CW     = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1,
  localparam int HW     = $clog2(RST_LEN + 2)
) (
  input logic          wclk,
  input logic          wrst,
  input logic          sclk,
  input logic          srst,
  input logic [CW-1:0] cnt,
  input logic          clr,
  input logic          sleep_s,
  input logic          rst_tog,
  input logic          wake_flag,
  input logic          wdt_rst,
  input logic          wake_req,
  input logic          wake_ack
);

  localparam logic [CW-1:0] TOP = CW'(TIMEOUT - 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge sclk) begin
    if (srst)                              hi_cnt <= '0;
    else if (wdt_rst && hi_cnt != '1)      hi_cnt <= hi_cnt + HW'(1);
    else if (!wdt_rst)                     hi_cnt <= '0;
  end

  // R2: count stays inside its period
  a_r2_cnt_bound: assert property (@(posedge wclk) disable iff (wrst)
    cnt <= TOP);

  // R2: one step per watchdog cycle when not cleared or wrapping
  a_r2_count_up: assert property (@(posedge wclk) disable iff (wrst)
    (!clr && cnt != TOP) |=> cnt == $past(cnt) + CW'(1));

  // R3 / R8: a clear request restarts the count
  a_r3_clear: assert property (@(posedge wclk) disable iff (wrst)
    clr |=> cnt == '0);

  // R4: expiry while awake flips the reset event level
  a_r4_reset_event: assert property (@(posedge wclk) disable iff (wrst)
    (cnt == TOP && !clr && !sleep_s) |=> rst_tog != $past(rst_tog));

  // R6: expiry while asleep never produces a reset event
  a_r6_no_reset_asleep: assert property (@(posedge wclk) disable iff (wrst)
    (cnt == TOP && sleep_s) |=> $stable(rst_tog));

  // R6: expiry while asleep raises the wake flag
  a_r6_wake_set: assert property (@(posedge wclk) disable iff (wrst)
    (cnt == TOP && !clr && sleep_s) |=> wake_flag);

  // R5: reset pulse never exceeds its length
  a_r5_pulse_max: assert property (@(posedge sclk) disable iff (srst)
    hi_cnt <= HW'(RST_LEN));

  // R5: a pulse that ends has the full length
  a_r5_pulse_len: assert property (@(posedge sclk) disable iff (srst)
    $fell(wdt_rst) |-> hi_cnt == HW'(RST_LEN));

  // R7: wake request only drops after an acknowledge
  a_r7_wake_hold: assert property (@(posedge sclk) disable iff (srst)
    $fell(wake_req) |-> $past(wake_ack));

endmodule

bind sleepwdt sleepwdt_chk #(.TIMEOUT(TIMEOUT), .RST_LEN(RST_LEN)) u_chk (
  .wclk      (wclk),
  .wrst      (wrst),
  .sclk      (sclk),
  .srst      (srst),
  .cnt       (wd_cnt),
  .clr       (wd_clr),
  .sleep_s   (wd_sleep),
  .rst_tog   (rst_tog),
  .wake_flag (wake_flag),
  .wdt_rst   (wdt_rst_o),
  .wake_req  (wake_req_o),
  .wake_ack  (wake_ack_i)
);

// File: tb/tb_sleepwdt.sv
`timescale 1ns/1ps
module tb_sleepwdt;

  localparam int SCLK_PERIOD = 10;
  localparam int WCLK_PERIOD = 26;
  localparam int TO          = 64;
  localparam int PLEN        = 5;
  localparam int EV_RST      = 1;
  localparam int EV_WAKE     = 2;

  typedef struct {
    int    kind;
    time   lo;
    time   hi;
    string tag;
  } exp_item_t;

  logic wclk = 1'b0;
  logic sclk = 1'b0;
  logic sclk_en = 1'b1;
  logic wrst = 1'b1;
  logic srst = 1'b1;
  logic kick_i = 1'b0;
  logic sleep_i = 1'b0;
  logic wake_ack_i = 1'b0;
  logic wdt_rst_o;
  logic wake_req_o;
  logic wake_wclk_o;

  int checks = 0;
  int errors = 0;
  int n_rst  = 0;
  exp_item_t exp_q[$];
  time last_rst_t = 0;
  int  hi_len = 0;
  logic rst_prev = 1'b0;
  logic req_prev = 1'b0;

  sleepwdt #(.TIMEOUT(TO), .RST_LEN(PLEN)) dut (
    .wclk        (wclk),
    .wrst        (wrst),
    .sclk        (sclk),
    .srst        (srst),
    .kick_i      (kick_i),
    .sleep_i     (sleep_i),
    .wake_ack_i  (wake_ack_i),
    .wdt_rst_o   (wdt_rst_o),
    .wake_req_o  (wake_req_o),
    .wake_wclk_o (wake_wclk_o)
  );

  always #(WCLK_PERIOD/2) wclk = ~wclk;

  always begin
    #(SCLK_PERIOD/2);
    if (sclk_en || sclk) sclk = ~sclk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int kind, input time lo, input time hi, input string tag);
    exp_item_t e;
    e.kind = kind; e.lo = lo; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic time win_lo(input time t);
    return t + time'((TO + 1) * WCLK_PERIOD);
  endfunction

  function automatic time win_hi(input time t);
    return t + time'((TO + 5) * WCLK_PERIOD + 6 * SCLK_PERIOD);
  endfunction

  task automatic pop_check(input int kind, input time t);
    exp_item_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event kind %0d at %0t: actual 1 expected 0",
               (kind == EV_RST) ? "R4" : "R6", kind, t);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || t < e.lo || t > e.hi) begin
        errors++;
        $display("FAIL %s event kind %0d at %0t: expected kind %0d in [%0t,%0t]",
                 e.tag, kind, t, e.kind, e.lo, e.hi);
      end
    end
  endtask

  // Monitor: pops expected items as outputs rise, measures pulse length.
  always @(negedge sclk) begin
    if (!srst) begin
      if (wdt_rst_o && !rst_prev) begin
        n_rst++;
        last_rst_t = $time;
        pop_check(EV_RST, $time);
      end
      if (wdt_rst_o) hi_len++;
      else if (rst_prev) begin
        check(hi_len == PLEN, "R5", "reset pulse length", hi_len, PLEN);
        hi_len = 0;
      end
      if (wake_req_o && !req_prev) pop_check(EV_WAKE, $time);
      rst_prev = wdt_rst_o;
      req_prev = wake_req_o;
    end
  end

  task automatic kick(output time t);
    @(negedge sclk);
    kick_i = 1'b1;
    t = $time;
    @(negedge sclk);
    kick_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge sclk);
  endtask

  task automatic ack_wake();
    @(negedge sclk);
    wake_ack_i = 1'b1;
    @(negedge sclk);
    wake_ack_i = 1'b0;
  endtask

  initial begin
    #(400 * 1000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    time t;
    time ts;
    time tw;
    int  saved;
    bit  held;

    repeat (4) @(negedge wclk);
    @(negedge sclk);
    check(wdt_rst_o == 1'b0, "R1", "reset output in reset", wdt_rst_o, 0);
    check(wake_req_o == 1'b0, "R1", "wake request in reset", wake_req_o, 0);
    check(wake_wclk_o == 1'b0, "R1", "wake level in reset", wake_wclk_o, 0);
    wrst = 1'b0;
    srst = 1'b0;

    // R3 / R4: kick, then first expiry while awake
    kick(t);
    push(EV_RST, win_lo(t), win_hi(t), "R4");
    wait_idle();

    // R2: free running, next reset one period later
    t = last_rst_t;
    push(EV_RST, t + time'(TO * WCLK_PERIOD - 3 * SCLK_PERIOD),
         t + time'(TO * WCLK_PERIOD + 3 * SCLK_PERIOD), "R2");
    wait_idle();

    // R3: regular kicks hold off any expiry
    saved = n_rst;
    for (int i = 0; i < 6; i++) begin
      kick(t);
      #(TO / 2 * WCLK_PERIOD);
    end
    check(n_rst == saved, "R3", "resets while kicked", n_rst, saved);
    kick(t);
    push(EV_RST, win_lo(t), win_hi(t), "R3");
    wait_idle();

    // R6 / R7: expiry while asleep gives a held wake request
    kick(t);
    @(negedge sclk);
    sleep_i = 1'b1;
    ts = $time;
    saved = n_rst;
    push(EV_WAKE, win_lo(ts), win_hi(ts), "R6");
    wait_idle();
    check(wake_wclk_o == 1'b1, "R6", "wake level in watchdog domain", wake_wclk_o, 1);
    held = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge sclk);
      if (!wake_req_o) held = 1'b0;
    end
    check(held, "R7", "wake request held without acknowledge", held, 1);
    check(n_rst == saved, "R6", "no reset pulse while asleep", n_rst, saved);
    ack_wake();
    @(negedge sclk);
    check(wake_req_o == 1'b0, "R7", "wake request after acknowledge", wake_req_o, 0);
    repeat (15) @(negedge sclk);
    check(wake_wclk_o == 1'b0, "R7", "wake level after handshake", wake_wclk_o, 0);
    sleep_i = 1'b0;
    kick(t);
    push(EV_RST, win_lo(t), win_hi(t), "R4");
    wait_idle();

    // R8 / R9: sleep entry restarts the count, system clock stopped
    kick(t);
    #(TO / 2 * WCLK_PERIOD);
    @(negedge sclk);
    sleep_i = 1'b1;
    ts = $time;
    push(EV_WAKE, win_lo(ts), win_hi(ts) + time'(400 * SCLK_PERIOD), "R6");
    repeat (5) @(negedge sclk);
    sclk_en = 1'b0;
    while (!wake_wclk_o && ($time < ts + time'(3 * TO * WCLK_PERIOD))) #1;
    tw = $time;
    check(wake_wclk_o == 1'b1, "R9", "wake level with system clock stopped",
          wake_wclk_o, 1);
    check(tw >= ts + time'(TO * WCLK_PERIOD), "R8", "wake time after sleep entry",
          tw, ts + time'(TO * WCLK_PERIOD));
    check(tw <= ts + time'((TO + 5) * WCLK_PERIOD), "R8", "wake time upper bound",
          tw, ts + time'((TO + 5) * WCLK_PERIOD));
    #(3 * SCLK_PERIOD);
    sclk_en = 1'b1;
    wait_idle();
    ack_wake();
    sleep_i = 1'b0;
    kick(t);
    repeat (20) @(negedge sclk);

    check(exp_q.size() == 0, "R4", "pending expected events", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule